// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This block is the digital controller for a memory power subsystem with three rails: the main memory supply, the termination supply and the termination reference. Two sleep-control levels from the system select one of three sleep states. The block turns that choice, together with a bias-ready flag and a thermal fault flag, into per-rail controls: enable, high-impedance (termination only) and discharge. The analog regulators and the threshold comparators are outside the block. It only consumes their digital results.

For the main supply it also runs a digital soft-start. An N-bit reference code climbs one step at a time from zero to full scale whenever the main rail is enabled. Switching stays forbidden until the comparator reports that the ramp has reached the existing feedback level. A pre-charged output therefore rises from where it already is, and is not first pulled down.

Every pin is a plain level, because no data stream crosses this block, so no valid/ready pair is used. The two sleep-control inputs are asynchronous and are synchronized inside the block. The bias-ready, thermal-fault and ramp-match flags are taken as synchronous to `clk`.

Top module: `pwr_seq_top`

## Requirements
- R1: Both sleep-control inputs pass through a two-flop synchronizer. A level change applied between two rising edges shows on the rail outputs after the second following edge, and not after the first.
- R2: With both request inputs high (running state), bias ready and no thermal fault, all three rail enables are high, and every high-impedance and discharge output is low.
- R3: With `req_term_i` low and `req_main_i` high (sleep state), the main and reference enables are high, the termination enable is low, `term_hiz_o` is high, and all discharge outputs are low.
- R4: With both request inputs low (off state), bias ready and no fault, every enable and `term_hiz_o` are low, and all three discharge outputs are high.
- R5: The combination `req_term_i` high with `req_main_i` low is decoded exactly as the off state.
- R6: While the main rail is enabled, `ss_code_o` starts at 0 and rises by exactly 1 every STEP_DIV clock cycles. While the main rail is disabled it is held at 0.
- R7: `ss_code_o` stops at full scale (all ones), and `ss_done_o` is high exactly while the code is at full scale with the main rail enabled.
- R8: `sw_allow_o` stays low after each ramp start until `ramp_at_fb_i` is seen high in a clock cycle. From the following edge it stays high, whatever `ramp_at_fb_i` does, until the main rail is disabled.
- R9: While `overtemp_i` is high, every enable, high-impedance and discharge output is low, in the same cycle. The ramp resets, and when the fault clears a fresh soft-start begins at code 0 with switching forbidden again.
- R10: While `bias_ok_i` is low, every rail output is low in the same cycle and the ramp is reset.
- R11: After reset, the synchronized state is off. With bias ready, the discharge outputs are high, and the code, done flag and switching permission are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_term_i | input | 1 | Asynchronous sleep control; high keeps the termination rail on in the running state |
| req_main_i | input | 1 | Asynchronous sleep control; high keeps the main and reference rails on |
| bias_ok_i | input | 1 | Bias supply above its power-on threshold |
| overtemp_i | input | 1 | Thermal fault flag, hysteresis applied outside |
| ramp_at_fb_i | input | 1 | Comparator result: the ramp has reached the feedback level |
| main_en_o | output | 1 | Main supply enable |
| main_dis_o | output | 1 | Main supply discharge |
| ref_en_o | output | 1 | Termination reference enable |
| ref_dis_o | output | 1 | Termination reference discharge |
| term_en_o | output | 1 | Termination supply enable |
| term_hiz_o | output | 1 | Termination output left high-impedance |
| term_dis_o | output | 1 | Termination supply discharge |
| sw_allow_o | output | 1 | Main converter switching permitted |
| ss_code_o | output | CODE_W | Soft-start reference code |
| ss_done_o | output | 1 | Soft-start complete |

## Verification
The bench walks every sleep state, including the undefined combination. A decoder that mapped that combination to the sleep state would leave the main rail on. It also steps each fault over a live state, and a design that let a fault reach the discharge paths, or that gated only some rails, shows a stray high output. Synchronizer latency is probed one edge early and one edge on time, so a missing or extra stage is caught. The ramp is sampled around the step boundaries and one cycle before and after full scale, which exposes an off-by-one divider or a code that wraps. The switching permission is checked both before and after the match flag drops, so a level-following design that does not latch it fails, and so does a design that forgets to clear it on a thermal restart.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_RUN   = 2'd2
  } slp_state_t;

  typedef struct packed {
    logic main_en;
    logic main_dis;
    logic ref_en;
    logic ref_dis;
    logic term_en;
    logic term_hiz;
    logic term_dis;
  } rail_ctl_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
  import pwr_seq_pkg::*;
(
  input  logic      req_term,
  input  logic      req_main,
  input  logic      active,
  output rail_ctl_t rails,
  output logic      main_on
);

  slp_state_t state;

  always_comb begin
    if (req_main && req_term) begin
      state = ST_RUN;
    end else if (req_main) begin
      state = ST_SLEEP;
    end else begin
      state = ST_OFF;
    end
  end

  always_comb begin
    rails = '0;
    if (active) begin
      case (state)
        ST_RUN: begin
          rails.main_en = 1'b1;
          rails.ref_en  = 1'b1;
          rails.term_en = 1'b1;
        end
        ST_SLEEP: begin
          rails.main_en  = 1'b1;
          rails.ref_en   = 1'b1;
          rails.term_hiz = 1'b1;
        end
        default: begin
          rails.main_dis = 1'b1;
          rails.ref_dis  = 1'b1;
          rails.term_dis = 1'b1;
        end
      endcase
    end
  end

  assign main_on = rails.main_en;

endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 117
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              at_fb,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              sw_allow
);

  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [DIV_W-1:0] div_cnt;
  logic             caught;
  logic             at_max;

  assign at_max = (code == CODE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      code    <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      code    <= '0;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt <= '0;
      if (!at_max) begin
        code <= code + 1'b1;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caught <= 1'b0;
    end else if (!run) begin
      caught <= 1'b0;
    end else if (at_fb) begin
      caught <= 1'b1;
    end
  end

  assign done     = at_max && run;
  assign sw_allow = caught && run;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 117
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_term_i,
  input  logic              req_main_i,
  input  logic              bias_ok_i,
  input  logic              overtemp_i,
  input  logic              ramp_at_fb_i,
  output logic              main_en_o,
  output logic              main_dis_o,
  output logic              ref_en_o,
  output logic              ref_dis_o,
  output logic              term_en_o,
  output logic              term_hiz_o,
  output logic              term_dis_o,
  output logic              sw_allow_o,
  output logic [CODE_W-1:0] ss_code_o,
  output logic              ss_done_o
);

  logic [1:0] req_sync;
  logic       active;
  logic       main_on;
  rail_ctl_t  rails;

  pwr_seq_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({req_main_i, req_term_i}),
    .sync_o (req_sync)
  );

  assign active = bias_ok_i && !overtemp_i;

  pwr_seq_decode u_decode (
    .req_term(req_sync[0]),
    .req_main(req_sync[1]),
    .active  (active),
    .rails   (rails),
    .main_on (main_on)
  );

  pwr_seq_ramp #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (main_on),
    .at_fb   (ramp_at_fb_i),
    .code    (ss_code_o),
    .done    (ss_done_o),
    .sw_allow(sw_allow_o)
  );

  assign main_en_o  = rails.main_en;
  assign main_dis_o = rails.main_dis;
  assign ref_en_o   = rails.ref_en;
  assign ref_dis_o  = rails.ref_dis;
  assign term_en_o  = rails.term_en;
  assign term_hiz_o = rails.term_hiz;
  assign term_dis_o = rails.term_dis;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              overtemp_i,
  input logic              bias_ok_i,
  input logic              main_en_o,
  input logic              main_dis_o,
  input logic              ref_en_o,
  input logic              ref_dis_o,
  input logic              term_en_o,
  input logic              term_hiz_o,
  input logic              term_dis_o,
  input logic              sw_allow_o,
  input logic [CODE_W-1:0] ss_code_o,
  input logic              ss_done_o
);

  // R2: termination never runs without the main supply
  a_r2_term_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
    term_en_o |-> (main_en_o && ref_en_o));

  // R3: a rail is never both driven and floating
  a_r3_hiz_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(term_en_o && term_hiz_o));

  // R4: discharge and enable never overlap on any rail
  a_r4_dis_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !((main_dis_o && main_en_o) || (ref_dis_o && ref_en_o) || (term_dis_o && term_en_o)));

  // R9: thermal fault forces every control low
  a_r9_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_i |-> !(main_en_o || ref_en_o || term_en_o || term_hiz_o ||
                     main_dis_o || ref_dis_o || term_dis_o || sw_allow_o));

  // R10: lost bias forces every control low
  a_r10_bias_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_ok_i |-> !(main_en_o || ref_en_o || term_en_o || term_hiz_o ||
                     main_dis_o || ref_dis_o || term_dis_o));

  // R6: code only climbs by one or returns to zero
  a_r6_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_code_o != $past(ss_code_o)) |->
      ((ss_code_o == $past(ss_code_o) + 1'b1) || (ss_code_o == '0)));

  // R7: done persists while the main rail stays on
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done_o |=> (ss_done_o || !main_en_o));

  // R8: switching only with the main rail enabled
  a_r8_sw_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
    sw_allow_o |-> main_en_o);

endmodule

bind pwr_seq_top pwr_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .overtemp_i(overtemp_i),
  .bias_ok_i (bias_ok_i),
  .main_en_o (main_en_o),
  .main_dis_o(main_dis_o),
  .ref_en_o  (ref_en_o),
  .ref_dis_o (ref_dis_o),
  .term_en_o (term_en_o),
  .term_hiz_o(term_hiz_o),
  .term_dis_o(term_dis_o),
  .sw_allow_o(sw_allow_o),
  .ss_code_o (ss_code_o),
  .ss_done_o (ss_done_o)
);

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;

  localparam int PERIOD   = 10;
  localparam int CODE_W   = 6;
  localparam int STEP_DIV = 3;
  localparam int NVEC     = 8;

  // {req_term, req_main, bias, overtemp, main_en, main_dis, ref_en, ref_dis, term_en, term_hiz, term_dis}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b1110_1010100,  // running: R2
    11'b0110_1010010,  // sleep: R3
    11'b0010_0101001,  // off: R4
    11'b1010_0101001,  // odd combination as off: R5
    11'b1111_0000000,  // running under fault: R9
    11'b0100_0000000,  // sleep without bias: R10
    11'b0011_0000000,  // off under fault: R9
    11'b1110_1010100   // running again: R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_term = 1'b0, req_main = 1'b0, bias_ok = 1'b1, overtemp = 1'b0, at_fb = 1'b0;
  logic main_en, main_dis, ref_en, ref_dis, term_en, term_hiz, term_dis, sw_allow, ss_done;
  logic [CODE_W-1:0] ss_code;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  pwr_seq_top #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) u_pwr_seq_top (
    .clk(clk), .rst_n(rst_n), .req_term_i(req_term), .req_main_i(req_main),
    .bias_ok_i(bias_ok), .overtemp_i(overtemp), .ramp_at_fb_i(at_fb),
    .main_en_o(main_en), .main_dis_o(main_dis), .ref_en_o(ref_en), .ref_dis_o(ref_dis),
    .term_en_o(term_en), .term_hiz_o(term_hiz), .term_dis_o(term_dis),
    .sw_allow_o(sw_allow), .ss_code_o(ss_code), .ss_done_o(ss_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int rails();
    return {main_en, main_dis, ref_en, ref_dis, term_en, term_hiz, term_dis};
  endfunction

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R11: reset state
    check("R11 rails", rails(), 7'b0101001);
    check("R11 code", ss_code, 0);
    check("R11 done", ss_done, 0);
    check("R11 sw", sw_allow, 0);

    // table walk for R2 R3 R4 R5 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      {req_term, req_main, bias_ok, overtemp} = VEC[v][10:7];
      edges(3);
      check($sformatf("rail table row %0d (R2 R3 R4 R5 R9 R10)", v), rails(), int'(VEC[v][6:0]));
    end

    // settle in off state
    {req_term, req_main, bias_ok, overtemp} = 4'b0010;
    edges(4);
    // R1: two-edge latency
    req_term = 1'b1; req_main = 1'b1;
    edges(1);
    check("R1 early", main_en, 0);
    edges(1);
    check("R1 on time", main_en, 1);
    check("R6 start", ss_code, 0);
    edges(3);
    check("R6 step1", ss_code, 1);
    edges(4);
    check("R6 step2", ss_code, 2);
    check("R8 before match", sw_allow, 0);
    at_fb = 1'b1;
    edges(1);
    check("R8 after match", sw_allow, 1);
    at_fb = 1'b0;
    edges(1);
    check("R8 latched", sw_allow, 1);
    edges(179);
    check("R7 code below max", ss_code, 62);
    check("R7 done low", ss_done, 0);
    edges(1);
    check("R7 code max", ss_code, 63);
    check("R7 done high", ss_done, 1);
    edges(5);
    check("R7 code saturates", ss_code, 63);

    // R9: thermal fault and restart
    overtemp = 1'b1;
    #1;
    check("R9 same cycle", rails(), 0);
    edges(1);
    check("R9 code reset", ss_code, 0);
    check("R9 done reset", ss_done, 0);
    overtemp = 1'b0;
    #1;
    check("R9 restart enable", main_en, 1);
    edges(3);
    check("R9 restart step", ss_code, 1);
    check("R9 sw relocked", sw_allow, 0);

    // R10: bias loss
    bias_ok = 1'b0;
    #1;
    check("R10 rails", rails(), 0);
    edges(1);
    check("R10 code reset", ss_code, 0);
    bias_ok = 1'b1;
    edges(2);

    // R5: odd combination from running
    req_term = 1'b1; req_main = 1'b0;
    edges(3);
    check("R5 rails", rails(), 7'b0101001);
    check("R5 code", ss_code, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule